// File: doc/BRIEF.md
# Aliased Set-Index Tag Lookup

This block holds the tag array of a set-associative cache and answers tag queries against it. For each request it derives a set index from the physical address, optionally hashing that index with low-order tag bits to spread strided traffic across sets. It then compares the address tag against every way of the selected set and returns the result one cycle later: hit, the way that hit, and that line's dirty and lock state.

The same request path can pin a resident line by setting its lock bit, or release it by clearing the bit. A pin request reports failure when the line is absent. A separate install port writes a whole tag entry directly into a chosen set and way. The refill logic uses this port; the bench uses it to preload entries. Data storage and refill sequencing live elsewhere.

Top module: `l2tag_lookup`

## Requirements
- R1: After reset `rsp_valid` is 0 and every tag entry is invalid, so any lookup misses.
- R2: With `alias_en` low, the set index is address bits [7 +: SET_BITS] (128-byte lines). It is returned on `rsp_index`.
- R3: With `alias_en` high, the set index is address bits [7 +: SET_BITS] XOR address bits [7+SET_BITS +: SET_BITS], kept to SET_BITS bits.
- R4: The address tag is bits [ADDR_W-1 : 7+SET_BITS]. A hit needs an entry in the indexed set whose valid bit is set and whose stored tag equals the address tag.
- R5: A request sampled on a clock edge produces `rsp_valid` high for exactly one cycle after that edge. Without a request, `rsp_valid` is low.
- R6: On a hit, `rsp_way` gives the matching way and `rsp_dirty` gives its dirty bit. On a miss, `rsp_hit`, `rsp_way` and `rsp_dirty` are 0.
- R7: Command code 1 (pin) on a hit sets the line's lock bit. The response shows `rsp_locked`=1 and `rsp_fail`=0, and later lookups see the lock.
- R8: A pin command that misses reports `rsp_fail`=1 and `rsp_hit`=0, and it changes no entry.
- R9: Command code 2 (release) clears the lock bit of a hit line and reports `rsp_hit`=1 with `rsp_locked`=0. On a miss it reports `rsp_hit`=0, and `rsp_fail` stays 0.
- R10: An install writes valid, dirty and tag into the given set and way and clears the lock bit. Installing with valid=0 makes that entry miss.
- R11: Command code 0 (lookup) and the spare code 3 only read. They report the stored lock bit as `rsp_locked` and never change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_cmd | input | 2 | 0 lookup, 1 pin, 2 release, 3 treated as lookup |
| req_addr | input | ADDR_W | Physical address |
| alias_en | input | 1 | Enable index hashing |
| fill_en | input | 1 | Install strobe |
| fill_way | input | WAY_W | Way to install into |
| fill_set | input | SET_BITS | Set to install into |
| fill_tag | input | TAG_W | Tag to install |
| fill_valid | input | 1 | Valid bit to install |
| fill_dirty | input | 1 | Dirty bit to install |
| rsp_valid | output | 1 | Response strobe |
| rsp_hit | output | 1 | Tag hit |
| rsp_way | output | WAY_W | Hitting way |
| rsp_dirty | output | 1 | Dirty bit of the hit line |
| rsp_locked | output | 1 | Lock bit of the line after the command |
| rsp_fail | output | 1 | Pin command could not lock a line |
| rsp_index | output | SET_BITS | Set index used by the request |

## Verification
The bench builds the block with its defaults: 128 sets, four ways and a 34-bit address, which gives a 20-bit tag. Seven index bits keep the hash easy to check by hand. For example, raw index 0x15 with tag 0xABCDE hashes to 0x4B. This lets the bench show that the same address hits in one set with hashing off and in another with hashing on. Four ways are enough to place lines in a middle way, a high way and a low way, and to confirm the reported way number for each.

// File: rtl/l2tag_pkg.sv
package l2tag_pkg;
    typedef enum logic [1:0] {
        CMD_LOOK   = 2'd0,
        CMD_PIN    = 2'd1,
        CMD_UNPIN  = 2'd2,
        CMD_SPARE  = 2'd3
    } tag_cmd_e;
endpackage

// File: rtl/l2tag_index.sv
module l2tag_index #(
    parameter int ADDR_W    = 34,
    parameter int LINE_BITS = 7,
    parameter int SET_BITS  = 7,
    parameter int TAG_W     = ADDR_W - LINE_BITS - SET_BITS
) (
    input  logic [ADDR_W-1:0]   addr,
    input  logic                alias_en,
    output logic [SET_BITS-1:0] index,
    output logic [TAG_W-1:0]    tag
);
    logic [LINE_BITS-1:0] unused_offset;
    logic [SET_BITS-1:0]  raw_idx;

    assign unused_offset = addr[LINE_BITS-1:0];
    assign raw_idx       = addr[LINE_BITS +: SET_BITS];
    assign tag           = addr[ADDR_W-1 : LINE_BITS+SET_BITS];

    // hash folds the lowest tag bits onto the index
    assign index = alias_en ? (raw_idx ^ tag[SET_BITS-1:0]) : raw_idx;
endmodule

// File: rtl/l2tag_match.sv
module l2tag_match #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 20,
    parameter int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]            vld_vec,
    input  logic [WAYS-1:0][TAG_W-1:0] tag_vec,
    input  logic [TAG_W-1:0]           tag,
    output logic                       any_hit,
    output logic [WAY_W-1:0]           hit_way
);
    logic [WAYS-1:0] hit_vec;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit_vec[w] = vld_vec[w] && (tag_vec[w] == tag);
    end

    always_comb begin
        hit_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (hit_vec[w]) hit_way = WAY_W'(w);
        end
    end

    assign any_hit = |hit_vec;
endmodule

// File: rtl/l2tag_lookup.sv
module l2tag_lookup
    import l2tag_pkg::*;
#(
    parameter int ADDR_W    = 34,
    parameter int SET_BITS  = 7,
    parameter int WAYS      = 4,
    parameter int LINE_BITS = 7,
    parameter int WAY_W     = $clog2(WAYS),
    parameter int TAG_W     = ADDR_W - LINE_BITS - SET_BITS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [1:0]          req_cmd,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic                alias_en,
    input  logic                fill_en,
    input  logic [WAY_W-1:0]    fill_way,
    input  logic [SET_BITS-1:0] fill_set,
    input  logic [TAG_W-1:0]    fill_tag,
    input  logic                fill_valid,
    input  logic                fill_dirty,
    output logic                rsp_valid,
    output logic                rsp_hit,
    output logic [WAY_W-1:0]    rsp_way,
    output logic                rsp_dirty,
    output logic                rsp_locked,
    output logic                rsp_fail,
    output logic [SET_BITS-1:0] rsp_index
);
    localparam int SETS = 1 << SET_BITS;

    typedef struct packed {
        logic             vld;
        logic             dirty;
        logic             lock;
        logic [TAG_W-1:0] tag;
    } entry_t;

    typedef struct packed {
        logic                valid;
        logic                hit;
        logic [WAY_W-1:0]    way;
        logic                dirty;
        logic                locked;
        logic                fail;
        logic [SET_BITS-1:0] index;
    } rsp_t;

    entry_t arr_q [SETS][WAYS];
    rsp_t   rsp_d, rsp_q;

    logic [SET_BITS-1:0]        idx;
    logic [TAG_W-1:0]           atag;
    logic [WAYS-1:0]            row_vld;
    logic [WAYS-1:0][TAG_W-1:0] row_tag;
    logic                       any_hit;
    logic [WAY_W-1:0]           hit_way;
    entry_t                     hit_ent;
    tag_cmd_e                   cmd;
    logic                       upd_en_d;
    logic                       upd_lock_d;

    assign cmd = tag_cmd_e'(req_cmd);

    l2tag_index #(
        .ADDR_W(ADDR_W), .LINE_BITS(LINE_BITS), .SET_BITS(SET_BITS), .TAG_W(TAG_W)
    ) u_index (
        .addr(req_addr), .alias_en(alias_en), .index(idx), .tag(atag)
    );

    for (genvar w = 0; w < WAYS; w++) begin : g_row
        assign row_vld[w] = arr_q[idx][w].vld;
        assign row_tag[w] = arr_q[idx][w].tag;
    end

    l2tag_match #(
        .WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)
    ) u_match (
        .vld_vec(row_vld), .tag_vec(row_tag), .tag(atag),
        .any_hit(any_hit), .hit_way(hit_way)
    );

    assign hit_ent = arr_q[idx][hit_way];

    always_comb begin
        rsp_d      = '0;
        upd_en_d   = 1'b0;
        upd_lock_d = 1'b0;
        if (req_valid) begin
            rsp_d.valid = 1'b1;
            rsp_d.index = idx;
            rsp_d.hit   = any_hit;
            rsp_d.way   = any_hit ? hit_way : '0;
            rsp_d.dirty = any_hit && hit_ent.dirty;
            case (cmd)
                CMD_PIN: begin
                    upd_en_d     = any_hit;
                    upd_lock_d   = 1'b1;
                    rsp_d.locked = any_hit;
                    // lock confirmed only when a line took the bit
                    rsp_d.fail   = !(any_hit && upd_lock_d);
                end
                CMD_UNPIN: begin
                    upd_en_d     = any_hit;
                    upd_lock_d   = 1'b0;
                    rsp_d.locked = 1'b0;
                end
                default: rsp_d.locked = any_hit && hit_ent.lock;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q <= '0;
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) arr_q[s][w] <= '0;
            end
        end else begin
            rsp_q <= rsp_d;
            if (upd_en_d) arr_q[idx][hit_way].lock <= upd_lock_d;
            if (fill_en) arr_q[fill_set][fill_way] <= '{vld: fill_valid, dirty: fill_dirty,
                                                         lock: 1'b0, tag: fill_tag};
        end
    end

    assign rsp_valid  = rsp_q.valid;
    assign rsp_hit    = rsp_q.hit;
    assign rsp_way    = rsp_q.way;
    assign rsp_dirty  = rsp_q.dirty;
    assign rsp_locked = rsp_q.locked;
    assign rsp_fail   = rsp_q.fail;
    assign rsp_index  = rsp_q.index;
endmodule

// File: rtl/l2tag_lookup_chk.sv
module l2tag_lookup_chk #(
    parameter int ADDR_W    = 34,
    parameter int SET_BITS  = 7,
    parameter int LINE_BITS = 7
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_valid,
    input logic [1:0]          req_cmd,
    input logic [ADDR_W-1:0]   req_addr,
    input logic                alias_en,
    input logic                rsp_valid,
    input logic                rsp_hit,
    input logic                rsp_locked,
    input logic                rsp_fail,
    input logic [SET_BITS-1:0] rsp_index
);
    assert_rsp_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    assert_rsp_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    assert_plain_index_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !alias_en) |=> rsp_index == $past(req_addr[LINE_BITS +: SET_BITS]));
    assert_hashed_index_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && alias_en) |=> rsp_index ==
            ($past(req_addr[LINE_BITS +: SET_BITS]) ^ $past(req_addr[LINE_BITS+SET_BITS +: SET_BITS])));
    assert_pin_result_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_cmd == 2'd1) |=> (rsp_locked == rsp_hit) && (rsp_fail == !rsp_hit));
    assert_fail_is_miss_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fail) |-> !rsp_hit);
    assert_unpin_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_cmd == 2'd2) |=> !rsp_locked && !rsp_fail);
endmodule

bind l2tag_lookup l2tag_lookup_chk #(
    .ADDR_W(ADDR_W), .SET_BITS(SET_BITS), .LINE_BITS(LINE_BITS)
) u_chk (.*);

// File: tb/test_l2tag_lookup.sv
module test_l2tag_lookup;
    localparam int ADDR_W = 34, SET_BITS = 7, WAYS = 4, LINE_BITS = 7;
    localparam int WAY_W = 2, TAG_W = ADDR_W - LINE_BITS - SET_BITS;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 0, alias_en = 0, fill_en = 0, fill_valid = 0, fill_dirty = 0;
    logic [1:0] req_cmd = 0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [WAY_W-1:0] fill_way = '0;
    logic [SET_BITS-1:0] fill_set = '0;
    logic [TAG_W-1:0] fill_tag = '0;
    logic rsp_valid, rsp_hit, rsp_dirty, rsp_locked, rsp_fail;
    logic [WAY_W-1:0] rsp_way;
    logic [SET_BITS-1:0] rsp_index;
    int checks = 0, errors = 0;

    always #2 clk = ~clk;

    l2tag_lookup #(.ADDR_W(ADDR_W), .SET_BITS(SET_BITS), .WAYS(WAYS), .LINE_BITS(LINE_BITS)) i_l2tag_lookup (
        .clk, .rst_n, .req_valid, .req_cmd, .req_addr, .alias_en, .fill_en, .fill_way,
        .fill_set, .fill_tag, .fill_valid, .fill_dirty, .rsp_valid, .rsp_hit, .rsp_way,
        .rsp_dirty, .rsp_locked, .rsp_fail, .rsp_index);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [ADDR_W-1:0] mk(input logic [TAG_W-1:0] t, input logic [SET_BITS-1:0] s,
                                            input logic [LINE_BITS-1:0] o);
        return {t, s, o};
    endfunction

    task automatic install(input int way, input int set, input logic [TAG_W-1:0] t,
                           input logic v, input logic d);
        @(negedge clk);
        fill_en = 1; fill_way = WAY_W'(way); fill_set = SET_BITS'(set);
        fill_tag = t; fill_valid = v; fill_dirty = d;
        @(negedge clk);
        fill_en = 0;
    endtask

    // issue one request, sample the registered response at the following negedge
    task automatic issue(input logic [1:0] c, input logic [ADDR_W-1:0] a, input logic al);
        @(negedge clk);
        req_valid = 1; req_cmd = c; req_addr = a; alias_en = al;
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic t_reset;
        chk("R1 rsp_valid after reset", rsp_valid, 0);
        issue(2'd0, mk(20'h0, 7'h0, 0), 0);
        chk("R1 empty array miss", rsp_hit, 0);
        chk("R6 miss way zero", rsp_way, 0);
    endtask

    task automatic t_plain;
        install(2, 'h15, 20'hABCDE, 1, 1);
        issue(2'd0, mk(20'hABCDE, 7'h15, 7'h3C), 0);
        chk("R5 rsp_valid", rsp_valid, 1);
        chk("R2 plain index", rsp_index, 'h15);
        chk("R4 hit", rsp_hit, 1);
        chk("R6 way", rsp_way, 2);
        chk("R6 dirty", rsp_dirty, 1);
        @(negedge clk);
        chk("R5 single-cycle strobe", rsp_valid, 0);
    endtask

    task automatic t_alias;
        issue(2'd0, mk(20'hABCDE, 7'h15, 0), 1);
        chk("R3 hashed index", rsp_index, 'h4B);
        chk("R3 hashed set misses", rsp_hit, 0);
        install(1, 'h4B, 20'hABCDE, 1, 0);
        issue(2'd0, mk(20'hABCDE, 7'h15, 0), 1);
        chk("R3 hashed hit", rsp_hit, 1);
        chk("R3 hashed way", rsp_way, 1);
        chk("R6 clean line", rsp_dirty, 0);
    endtask

    task automatic t_mismatch;
        issue(2'd0, mk(20'hABCDF, 7'h15, 0), 0);
        chk("R4 tag mismatch misses", rsp_hit, 0);
        install(2, 'h15, 20'hABCDE, 0, 1);
        issue(2'd0, mk(20'hABCDE, 7'h15, 0), 0);
        chk("R10 invalidated entry misses", rsp_hit, 0);
    endtask

    task automatic t_pin;
        install(3, 'h22, 20'h12345, 1, 0);
        issue(2'd1, mk(20'h12345, 7'h22, 0), 0);
        chk("R7 pin hit", rsp_hit, 1);
        chk("R7 pin locked", rsp_locked, 1);
        chk("R7 pin no fail", rsp_fail, 0);
        issue(2'd0, mk(20'h12345, 7'h22, 0), 0);
        chk("R7 lock persists", rsp_locked, 1);
        issue(2'd3, mk(20'h12345, 7'h22, 0), 0);
        chk("R11 spare code reads lock", rsp_locked, 1);
        chk("R11 spare code no fail", rsp_fail, 0);
        issue(2'd0, mk(20'h12345, 7'h22, 0), 0);
        chk("R11 lock unchanged", rsp_locked, 1);
    endtask

    task automatic t_pin_miss;
        issue(2'd1, mk(20'h54321, 7'h22, 0), 0);
        chk("R8 pin miss fail", rsp_fail, 1);
        chk("R8 pin miss hit", rsp_hit, 0);
        issue(2'd0, mk(20'h54321, 7'h22, 0), 0);
        chk("R8 no entry created", rsp_hit, 0);
        issue(2'd0, mk(20'h12345, 7'h22, 0), 0);
        chk("R8 neighbour lock kept", rsp_locked, 1);
    endtask

    task automatic t_unpin;
        issue(2'd2, mk(20'h12345, 7'h22, 0), 0);
        chk("R9 release hit", rsp_hit, 1);
        chk("R9 release locked", rsp_locked, 0);
        issue(2'd0, mk(20'h12345, 7'h22, 0), 0);
        chk("R9 lock cleared", rsp_locked, 0);
        issue(2'd2, mk(20'h0F0F0, 7'h22, 0), 0);
        chk("R9 release miss", rsp_hit, 0);
        chk("R9 release miss no fail", rsp_fail, 0);
    endtask

    task automatic t_refill;
        issue(2'd1, mk(20'h12345, 7'h22, 0), 0);
        install(3, 'h22, 20'h12345, 1, 1);
        issue(2'd0, mk(20'h12345, 7'h22, 0), 0);
        chk("R10 install clears lock", rsp_locked, 0);
        chk("R10 install dirty", rsp_dirty, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_plain();
        t_alias();
        t_mismatch();
        t_pin();
        t_pin_miss();
        t_unpin();
        t_refill();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual running expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule